// File: doc/BRIEF.md
# Flash Sector Write-Protection Gate

This block decides whether a program or sector-erase request to an eleven-sector flash array may start. Two active-low hardware protect pins each cover their own part of the array. The top sector has its own pin, and the remaining sectors share a second pin. Each sector also has a software lock bit. A request is granted only if its sector exists, the pin that covers that sector is high, and the sector's lock bit is clear. A refused request produces a one-cycle error pulse and sets a sticky violation bit.

The block also owns the array's reset-time state. It uses a synchronous active-low reset, sampled on the clock. Reset does four things:
- it sets every lock bit;
- it returns the read mode to array data;
- it cuts short any operation in flight and marks that sector's contents as untrustworthy;
- it starts a recovery window, during which every command is ignored.

A plain cycle counter stands in for the duration of an operation. The block signals busy for that long and then pulses done. The protect pins are treated as asynchronous and pass through a two-flop synchronizer before the decision uses them.

Top module: `flash_protect_gate`

## Requirements
- R1: While the synchronized `bootLockN` is 0, a request to sector 10 (the top sector) is denied. `bootLockN` has no effect on sectors 0 to 9.
- R2: While the synchronized `protectN` is 0, a request to any of sectors 0 to 9 is denied. `protectN` has no effect on sector 10.
- R3: Each protect pin passes through two flops. A pin change driven before clock edge k first affects a request sampled at edge k+2. A request sampled at edge k+1 is still decided on the old pin value.
- R4: A request to a sector whose lock bit is 1 is denied. A lock write (`lockWrEn`, `lockWrSector`, `lockWrValue`, where 1 means locked) updates that sector's bit. Lock writes to sector numbers 11 to 15 are dropped.
- R5: Reset sets the lock bit of every sector to 1, whatever its earlier value.
- R6: `statusMode` is 0 (array read) after reset. It becomes 1 when a request is granted, and `clrStatus` returns it to 0.
- R7: If reset is sampled while `busy` is 1, the operation ends at once and `sectorBad` bit n is set for the active sector n. A later erase of sector n that runs to completion clears bit n.
- R8: After reset is released, `ready` rises after exactly RECOVERY_CYCLES clock edges. Until then, requests, lock writes and `clrStatus` are ignored.
- R9: A denied request gives `reqDeny` high for exactly one cycle and sets `violation`. `violation` stays set until `clrStatus` or reset clears it.
- R10: A granted operation holds `busy` for OP_CYCLES cycles and then pulses `opDone` for one cycle. Requests and lock writes presented while busy are ignored.
- R11: A request naming sector 11 to 15 is denied.
- R12: An accepted request gives `reqGrant` high for exactly one cycle, in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bootLockN | input | 1 | Top-sector protect pin, active low, asynchronous |
| protectN | input | 1 | Lower-sector protect pin, active low, asynchronous |
| reqValid | input | 1 | Program/erase request strobe |
| reqSector | input | 4 | Target sector of the request |
| reqErase | input | 1 | 1 = sector erase, 0 = program |
| lockWrEn | input | 1 | Lock register write strobe |
| lockWrSector | input | 4 | Sector whose lock bit is written |
| lockWrValue | input | 1 | New lock bit, 1 = locked |
| clrStatus | input | 1 | Clears violation and returns to array-read mode |
| reqGrant | output | 1 | One-cycle pulse: request accepted |
| reqDeny | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | Operation in progress |
| opDone | output | 1 | One-cycle pulse when an operation ends normally |
| ready | output | 1 | Recovery window after reset has elapsed |
| violation | output | 1 | Sticky protect-violation status |
| statusMode | output | 1 | 1 = status-read mode, 0 = array-read mode |
| sectorBad | output | 11 | Per-sector contents-invalid flags from aborted operations |

## Verification
The hardest case to reach is an abort: reset has to land while an operation is running, and the damage can only be seen afterwards. The bench unlocks a sector, starts an erase on it, and asserts reset one cycle later. It then checks that exactly that sector's invalid flag is set and that its lock bit came back set. Finally it unlocks the sector again and runs a full erase to clear the flag. The synchronizer delay is reached by changing a pin and issuing a request on the very next clock edge, which must still be decided on the old pin value.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  // strobes from the control unit to the datapath, valid for the current edge
  typedef struct packed {
    logic startOp;
    logic denyOp;
    logic lockWrite;
    logic clearStatus;
    logic finishOp;
    logic abortOp;
  } ctrlStrobes_t;
endpackage

// File: rtl/fpg_pin_sync.sv
module fpg_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut
);
  // reset value 0 reads as "protected" until the pins have been sampled
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], pinIn[b]};
    end
    assign pinOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/fpg_ctrl.sv
module fpg_ctrl
  import fpg_pkg::*;
#(
  parameter int RECOVERY_CYCLES = 16,
  parameter int OP_CYCLES       = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqAllowed,
  input  logic         lockWrEn,
  input  logic         clrStatus,
  output ctrlStrobes_t strb,
  output logic         ready,
  output logic         busy,
  output logic         grant,
  output logic         deny,
  output logic         opDone
);
  localparam int REC_W = $clog2(RECOVERY_CYCLES + 1);
  localparam int OP_W  = $clog2(OP_CYCLES + 1);

  logic [REC_W-1:0] recCnt;
  logic [OP_W-1:0]  opCnt;
  logic             accept;

  assign accept = ready && !busy;

  always_comb begin
    strb             = '0;
    strb.startOp     = accept && reqValid && reqAllowed;
    strb.denyOp      = accept && reqValid && !reqAllowed;
    strb.lockWrite   = accept && lockWrEn;
    strb.clearStatus = accept && clrStatus;
    strb.finishOp    = busy && (opCnt == OP_W'(OP_CYCLES - 1));
    strb.abortOp     = !rstN && busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recCnt <= '0;
      ready  <= 1'b0;
      busy   <= 1'b0;
      opCnt  <= '0;
      grant  <= 1'b0;
      deny   <= 1'b0;
      opDone <= 1'b0;
    end else begin
      grant  <= strb.startOp;
      deny   <= strb.denyOp;
      opDone <= strb.finishOp;
      if (!ready) begin
        if (recCnt == REC_W'(RECOVERY_CYCLES - 1)) ready <= 1'b1;
        else                                       recCnt <= recCnt + 1'b1;
      end
      if (strb.startOp) begin
        busy  <= 1'b1;
        opCnt <= '0;
      end else if (strb.finishOp) begin
        busy <= 1'b0;
      end else if (busy) begin
        opCnt <= opCnt + 1'b1;
      end
    end
  end

  // R8
  busy_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ready);
  // R12
  grant_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> !grant);
  // R9
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && deny));
  // R10
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startOp |=> busy);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> !busy);
endmodule

// File: rtl/fpg_datapath.sv
module fpg_datapath
  import fpg_pkg::*;
#(
  parameter int NUM_SECTORS = 11,
  parameter int SECT_W      = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic                   bootOk,
  input  logic                   lowerOk,
  input  logic [SECT_W-1:0]      reqSector,
  input  logic                   reqErase,
  input  logic [SECT_W-1:0]      lockWrSector,
  input  logic                   lockWrValue,
  output logic                   reqAllowed,
  output logic                   violation,
  output logic                   statusMode,
  output logic [NUM_SECTORS-1:0] sectorBad
);
  localparam logic [SECT_W-1:0] TOP_SECTOR = SECT_W'(NUM_SECTORS - 1);

  logic [NUM_SECTORS-1:0] lockReg;
  logic [SECT_W-1:0]      activeSector = '0;
  logic                   activeErase  = 1'b0;
  logic [NUM_SECTORS-1:0] badMap       = '0;
  logic                   reqInRange, wrInRange, reqLocked, pinOk;

  assign reqInRange = reqSector <= TOP_SECTOR;
  assign wrInRange  = lockWrSector <= TOP_SECTOR;
  assign reqLocked  = reqInRange ? lockReg[reqSector] : 1'b1;
  assign pinOk      = (reqSector == TOP_SECTOR) ? bootOk : lowerOk;
  assign reqAllowed = reqInRange && !reqLocked && pinOk;

  always_ff @(posedge clk) begin
    if (!rstN)                              lockReg <= '1;
    else if (strb.lockWrite && wrInRange)   lockReg[lockWrSector] <= lockWrValue;
  end

  // kept across reset so an abort can still name its sector
  always_ff @(posedge clk) begin
    if (strb.startOp) begin
      activeSector <= reqSector;
      activeErase  <= reqErase;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.abortOp)                         badMap[activeSector] <= 1'b1;
    else if (strb.finishOp && activeErase)    badMap[activeSector] <= 1'b0;
  end
  assign sectorBad = badMap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violation  <= 1'b0;
      statusMode <= 1'b0;
    end else begin
      if (strb.clearStatus) begin
        violation  <= 1'b0;
        statusMode <= 1'b0;
      end
      if (strb.denyOp)  violation  <= 1'b1;
      if (strb.startOp) statusMode <= 1'b1;
    end
  end

  // R5
  locks_default_chk: assert property (@(posedge clk)
    !rstN |=> (&lockReg));
  // R6
  array_mode_chk: assert property (@(posedge clk)
    !rstN |=> !statusMode);
  // R9
  violation_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.denyOp |=> violation);
  // R4
  start_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startOp |-> (reqSector <= TOP_SECTOR) && !lockReg[reqSector]);
endmodule

// File: rtl/flash_protect_gate.sv
module flash_protect_gate
  import fpg_pkg::*;
#(
  parameter int NUM_SECTORS     = 11,
  parameter int SECT_W          = $clog2(NUM_SECTORS),
  parameter int RECOVERY_CYCLES = 16,
  parameter int OP_CYCLES       = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bootLockN,
  input  logic                   protectN,
  input  logic                   reqValid,
  input  logic [SECT_W-1:0]      reqSector,
  input  logic                   reqErase,
  input  logic                   lockWrEn,
  input  logic [SECT_W-1:0]      lockWrSector,
  input  logic                   lockWrValue,
  input  logic                   clrStatus,
  output logic                   reqGrant,
  output logic                   reqDeny,
  output logic                   busy,
  output logic                   opDone,
  output logic                   ready,
  output logic                   violation,
  output logic                   statusMode,
  output logic [NUM_SECTORS-1:0] sectorBad
);
  ctrlStrobes_t strb;
  logic [1:0]   pinSync;
  logic         reqAllowed;

  fpg_pin_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn({bootLockN, protectN}), .pinOut(pinSync)
  );

  fpg_ctrl #(.RECOVERY_CYCLES(RECOVERY_CYCLES), .OP_CYCLES(OP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAllowed(reqAllowed),
    .lockWrEn(lockWrEn), .clrStatus(clrStatus), .strb(strb), .ready(ready),
    .busy(busy), .grant(reqGrant), .deny(reqDeny), .opDone(opDone)
  );

  fpg_datapath #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bootOk(pinSync[1]), .lowerOk(pinSync[0]),
    .reqSector(reqSector), .reqErase(reqErase), .lockWrSector(lockWrSector),
    .lockWrValue(lockWrValue), .reqAllowed(reqAllowed), .violation(violation),
    .statusMode(statusMode), .sectorBad(sectorBad)
  );
endmodule

// File: tb/sim_flash_protect_gate.sv
`timescale 1ns/100ps
module sim_flash_protect_gate;
  localparam int NS  = 11;
  localparam int REC = 5;
  localparam int OPC = 3;

  logic clk = 0, rstN = 0, bootLockN = 1, protectN = 1, reqValid = 0, reqErase = 0;
  logic [3:0] reqSector = 0, lockWrSector = 0;
  logic lockWrEn = 0, lockWrValue = 0, clrStatus = 0;
  logic reqGrant, reqDeny, busy, opDone, ready, violation, statusMode;
  logic [NS-1:0] sectorBad;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_protect_gate #(.RECOVERY_CYCLES(REC), .OP_CYCLES(OPC)) u0 (
    .clk(clk), .rstN(rstN), .bootLockN(bootLockN), .protectN(protectN),
    .reqValid(reqValid), .reqSector(reqSector), .reqErase(reqErase),
    .lockWrEn(lockWrEn), .lockWrSector(lockWrSector), .lockWrValue(lockWrValue),
    .clrStatus(clrStatus), .reqGrant(reqGrant), .reqDeny(reqDeny), .busy(busy),
    .opDone(opDone), .ready(ready), .violation(violation),
    .statusMode(statusMode), .sectorBad(sectorBad)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic lockWr(input int sec, input bit val);
    @(negedge clk); lockWrEn = 1; lockWrSector = 4'(sec); lockWrValue = val;
    @(negedge clk); lockWrEn = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    repeat (REC) @(negedge clk);
    check(ready == 1, "R8 ready after recovery", int'(ready), 1);
  endtask

  // issues one request; returns grant seen in the following cycle
  task automatic request(input int sec, input bit erase, input bit expGrant, input string req);
    @(negedge clk); reqValid = 1; reqSector = 4'(sec); reqErase = erase;
    @(negedge clk); reqValid = 0;
    check(reqGrant == expGrant && reqDeny == !expGrant, req, int'({reqGrant, reqDeny}),
          int'({expGrant, !expGrant}));
    if (reqGrant) begin
      repeat (OPC - 1) @(negedge clk);
      check(busy == 1, "R10 busy held", int'(busy), 1);
      @(negedge clk);
      check(busy == 0 && opDone == 1, "R10 done pulse", int'({busy, opDone}), 1);
    end else begin
      @(negedge clk);
      check(reqDeny == 0 && violation == 1, "R9 deny pulse and sticky",
            int'({reqDeny, violation}), 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready == 0 && busy == 0 && violation == 0 && statusMode == 0 && reqGrant == 0,
          "R6 reset state", int'({ready, busy, violation, statusMode}), 0);
    // R8: release, try commands inside the window
    rstN = 1;
    for (int i = 1; i <= REC; i++) begin
      if (i == 1) begin
        lockWrEn = 1; lockWrSector = 0; lockWrValue = 0; reqValid = 1; reqSector = 0;
      end
      @(negedge clk);
      if (i == 1) begin lockWrEn = 0; reqValid = 0; end
      if (i == 2) check(reqGrant == 0 && reqDeny == 0, "R8 ignored in recovery",
                        int'({reqGrant, reqDeny}), 0);
      if (i < REC) check(ready == 0, "R8 ready low", int'(ready), 0);
      else         check(ready == 1, "R8 ready rise", int'(ready), 1);
    end
    request(0, 0, 0, "R8 lock write dropped in recovery");

    // R1 R2 R4 R11 R12 sweep
    for (int pins = 0; pins < 4; pins++) begin
      @(negedge clk); bootLockN = pins[1]; protectN = pins[0];
      repeat (3) @(negedge clk);
      for (int sec = 0; sec < 16; sec++) begin
        for (int lk = 0; lk < 2; lk++) begin
          bit exp;
          if (sec < NS) lockWr(sec, lk[0]);
          exp = (sec < NS) && !lk[0] && ((sec == NS - 1) ? pins[1] : pins[0]);
          request(sec, lk[0], exp,
                  sec >= NS ? "R11 out of range" : (sec == NS - 1 ? "R1 R4 R12 top sector"
                                                                  : "R2 R4 R12 lower sector"));
        end
      end
    end

    // R6 R9: clear status
    check(statusMode == 1, "R6 status after grant", int'(statusMode), 1);
    @(negedge clk); clrStatus = 1;
    @(negedge clk); clrStatus = 0;
    check(statusMode == 0 && violation == 0, "R9 R6 clear status",
          int'({statusMode, violation}), 0);

    // R3: pin change then request on next edge is decided on the old value
    @(negedge clk); bootLockN = 1; protectN = 1;
    repeat (3) @(negedge clk);
    lockWr(3, 0);
    @(negedge clk); protectN = 0;
    request(3, 0, 1, "R3 old pin value still used");
    request(3, 0, 0, "R3 new pin value applied");
    @(negedge clk); protectN = 1;
    repeat (3) @(negedge clk);

    // R10: commands during busy are ignored
    lockWr(5, 0); lockWr(6, 0);
    @(negedge clk); reqValid = 1; reqSector = 5; reqErase = 0;
    @(negedge clk); reqValid = 1; reqSector = 6;
    lockWrEn = 1; lockWrSector = 5; lockWrValue = 1;
    @(negedge clk); reqValid = 0; lockWrEn = 0;
    check(reqGrant == 0 && reqDeny == 0 && busy == 1, "R10 request while busy ignored",
          int'({reqGrant, reqDeny}), 0);
    repeat (OPC) @(negedge clk);
    request(5, 0, 1, "R10 lock write while busy ignored");

    // R7 R5: abort by reset
    @(negedge clk); clrStatus = 1;
    @(negedge clk); clrStatus = 0;
    lockWr(4, 0);
    @(negedge clk); reqValid = 1; reqSector = 4; reqErase = 1;
    @(negedge clk); reqValid = 0;
    check(busy == 1, "R7 operation started", int'(busy), 1);
    rstN = 0;
    @(negedge clk);
    check(busy == 0 && sectorBad == NS'(1 << 4), "R7 abort flags sector",
          int'(sectorBad), 1 << 4);
    check(violation == 0 && statusMode == 0, "R9 R6 reset clears status",
          int'({violation, statusMode}), 0);
    rstN = 1;
    repeat (REC) @(negedge clk);
    request(4, 1, 0, "R5 lock set again after reset");
    request(NS - 1, 1, 0, "R5 top lock set after reset");
    lockWr(4, 0);
    request(4, 1, 1, "R7 erase after abort");
    check(sectorBad == '0, "R7 erase clears invalid flag", int'(sectorBad), 0);
    doReset();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule